// File: doc/BRIEF.md
# Locked-Rotor Retry Timer

This block protects a three-phase fan motor drive against a stalled rotor. While the drive runs, it watches a single Hall sensor (phase 1) for rising edges. Each edge shows that the rotor is turning and restarts an on-window count. If a whole on-window passes without an edge, the block withdraws the enable for the upper (PWM) switches. It then holds that enable low for an off-window fifteen times as long, and re-arms automatically. The 1:15 duty keeps the average stall current low. Because the block re-arms on its own, a motor that was briefly blocked restarts without outside help.

All timing comes from one slow tick, derived from the block clock by a prescaler. The on-window, the off-window and the power-up reset interval are whole numbers of ticks. When the start command is raised, the block first runs a reset interval, during which it asks for every output switch, upper and lower, to be held off. The on-window follows. Dropping the start command puts the block into stop mode at once. Stop mode clears every timer, so the next start begins from a fresh reset interval.

The block also drives the tachometer output. This is an open-drain style, active-low copy of the synchronized Hall phase-1 signal, so it runs at the same frequency as that input.

Top module: `lock_retry_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `drive_en` and `por_active` are 0 and `fg_n` is 1 (released).
- R2: One clock edge after `run` is sampled low, `drive_en` and `por_active` are both 0, and the prescaler and window counters are cleared. When `run` is raised again, the reset interval restarts with its full length.
- R3: The prescaler is clear while `run` is low and fires its first tick TICK_DIV-1 cycles after `run` is sampled high. The reset interval therefore holds `por_active` high, with `drive_en` low, for exactly POR_TICKS*TICK_DIV-1 cycles. `drive_en` rises on the cycle `por_active` falls.
- R4: With no rising edge on `hall1`, `drive_en` stays high for exactly ON_TICKS*TICK_DIV cycles and then falls.
- R5: After a forced drop, `drive_en` stays low for exactly OFF_RATIO*ON_TICKS*TICK_DIV cycles (OFF_RATIO defaults to 15). It then rises again with no outside action and starts a new on-window.
- R6: A rising edge of `hall1` seen while `drive_en` is high restarts the on-window count. Edges spaced closer than the on-window keep `drive_en` high indefinitely.
- R7: Edges of `hall1` during the off-window or the reset interval have no effect: those windows keep their full length.
- R8: `fg_n` equals the complement of `hall1` as sampled three clock edges earlier (two synchronizer flops plus the output register). It is 0 while `hall1` is high.
- R9: `drive_en` and `por_active` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start command; low selects stop mode |
| hall1 | input | 1 | Asynchronous Hall sensor phase 1 level |
| drive_en | output | 1 | Enable for the upper (PWM) switches |
| por_active | output | 1 | High while the start-up reset interval holds all switches off |
| fg_n | output | 1 | Active-low tachometer output following Hall phase 1 |

## Verification
The bench first holds Hall phase 1 still. This shows the bare window lengths: reset interval, on-window timeout and the full fifteen-fold off-window. It then toggles the input faster than the on-window, which tells a working restart-on-edge apart from a free-running timeout. It also toggles the input during the off-window, which shows whether edges there are wrongly allowed to shorten the penalty. A stop command dropped mid-penalty, followed by a restart, checks that the prescaler and counters really start fresh. Long random stretches then mix Hall periods near and beyond the on-window with occasional stops. These are compared cycle by cycle against a bench model.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POR  = 2'd1,
    ST_ON   = 2'd2,
    ST_OFF  = 2'd3
  } lock_state_t;
endpackage

// File: rtl/lock_tick_gen.sv
// Slow timebase: one-cycle tick every TICK_DIV clocks while running.
module lock_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || !run)      pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/lock_hall_sync.sv
// Two-flop synchronizer, rising-edge detect and registered tach output.
module lock_hall_sync (
  input  logic clk,
  input  logic rst,
  input  logic hall_async,
  output logic hall_rise,
  output logic fg_n
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
      fg_n <= 1'b1;
    end else begin
      s1_q <= hall_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
      fg_n <= ~s2_q;
    end
  end

  assign hall_rise = s2_q & ~s3_q;
endmodule

// File: rtl/lock_ctrl.sv
// Window sequencer: reset interval, on-window watch, off-window penalty.
module lock_ctrl
  import lock_pkg::*;
#(
  parameter int ON_TICKS  = 16,
  parameter int OFF_RATIO = 15,
  parameter int POR_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic hall_rise,
  output logic drive_en,
  output logic por_active
);
  localparam int OFF_TICKS = ON_TICKS * OFF_RATIO;
  localparam int MAX_A     = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
  localparam int MAX_T     = (MAX_A > POR_TICKS) ? MAX_A : POR_TICKS;
  localparam int CNT_W     = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);
  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_TICKS - 1);

  lock_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!run) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_POR;
          cnt_d   = '0;
        end
        ST_POR: if (tick) begin
          if (cnt_q == POR_LAST) begin
            state_d = ST_ON;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_ON: begin
          if (hall_rise) cnt_d = '0;
          else if (tick) begin
            if (cnt_q == ON_LAST) begin
              state_d = ST_OFF;
              cnt_d   = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        ST_OFF: if (tick) begin
          if (cnt_q == OFF_LAST) begin
            state_d = ST_ON;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      drive_en   <= 1'b0;
      por_active <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      drive_en   <= (state_d == ST_ON);
      por_active <= (state_d == ST_POR);
    end
  end
endmodule

// File: rtl/lock_retry_timer.sv
module lock_retry_timer #(
  parameter int TICK_DIV  = 4,
  parameter int ON_TICKS  = 16,
  parameter int OFF_RATIO = 15,
  parameter int POR_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hall1,
  output logic drive_en,
  output logic por_active,
  output logic fg_n
);
  logic tick;
  logic hall_rise;

  lock_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  lock_hall_sync u_sync (
    .clk       (clk),
    .rst       (rst),
    .hall_async(hall1),
    .hall_rise (hall_rise),
    .fg_n      (fg_n)
  );

  lock_ctrl #(
    .ON_TICKS (ON_TICKS),
    .OFF_RATIO(OFF_RATIO),
    .POR_TICKS(POR_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .tick      (tick),
    .hall_rise (hall_rise),
    .drive_en  (drive_en),
    .por_active(por_active)
  );
endmodule

// File: rtl/lock_retry_checker.sv
module lock_retry_checker #(
  parameter int TICK_DIV  = 4,
  parameter int ON_TICKS  = 16,
  parameter int OFF_RATIO = 15
) (
  input logic clk,
  input logic rst,
  input logic run,
  input logic hall_rise,
  input logic drive_en,
  input logic por_active
);
  localparam int ON_CLKS  = ON_TICKS * TICK_DIV;
  localparam int OFF_CLKS = ON_TICKS * OFF_RATIO * TICK_DIV;
  localparam int CW       = $clog2(OFF_CLKS + 2) + 1;

  logic [CW-1:0] off_run_q;
  logic [CW-1:0] on_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_run_q <= '0;
      on_run_q  <= '0;
    end else begin
      if (!drive_en && run && !por_active) off_run_q <= off_run_q + 1'b1;
      else                                 off_run_q <= '0;
      if (drive_en && !hall_rise)          on_run_q <= on_run_q + 1'b1;
      else                                 on_run_q <= '0;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(drive_en && por_active)); // R9

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!drive_en && !por_active)); // R2

  AST_START_POR: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> por_active); // R3

  AST_ON_BOUND: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> (on_run_q < CW'(ON_CLKS))); // R4

  AST_OFF_LEN: assert property (@(posedge clk) disable iff (rst)
    ($rose(drive_en) && !$past(por_active)) |-> (off_run_q == CW'(OFF_CLKS))); // R5
endmodule

bind lock_retry_timer lock_retry_checker #(
  .TICK_DIV (TICK_DIV),
  .ON_TICKS (ON_TICKS),
  .OFF_RATIO(OFF_RATIO)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .hall_rise (hall_rise),
  .drive_en  (drive_en),
  .por_active(por_active)
);

// File: tb/sim_lock_retry_timer.sv
`timescale 1ns/1ps
module sim_lock_retry_timer;
  localparam int TICK_DIV  = 4;
  localparam int ON_TICKS  = 16;
  localparam int OFF_RATIO = 15;
  localparam int POR_TICKS = 4;
  localparam int ON_CLKS   = ON_TICKS * TICK_DIV;
  localparam int OFF_CLKS  = ON_TICKS * OFF_RATIO * TICK_DIV;
  localparam int POR_CLKS  = POR_TICKS * TICK_DIV - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic hall1 = 1'b0;
  logic drive_en, por_active, fg_n;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lock_retry_timer #(
    .TICK_DIV(TICK_DIV), .ON_TICKS(ON_TICKS),
    .OFF_RATIO(OFF_RATIO), .POR_TICKS(POR_TICKS)
  ) u0 (
    .clk(clk), .rst(rst), .run(run), .hall1(hall1),
    .drive_en(drive_en), .por_active(por_active), .fg_n(fg_n)
  );

  // Bench model built from the requirements (0 idle, 1 reset interval, 2 on, 3 off)
  int m_st = 0, m_cnt = 0, m_pc = 0;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0, m_fg = 1;

  always @(posedge clk) begin
    int ns, nc;
    bit tk, rs;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pc = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_fg = 1;
    end else begin
      tk = run && (m_pc == TICK_DIV - 1);
      rs = m_s2 && !m_s3;
      ns = m_st; nc = m_cnt;
      if (!run) begin ns = 0; nc = 0; end
      else case (m_st)
        0: begin ns = 1; nc = 0; end
        1: if (tk) begin
             if (m_cnt == POR_TICKS - 1) begin ns = 2; nc = 0; end else nc = m_cnt + 1;
           end
        2: if (rs) nc = 0;
           else if (tk) begin
             if (m_cnt == ON_TICKS - 1) begin ns = 3; nc = 0; end else nc = m_cnt + 1;
           end
        default: if (tk) begin
             if (m_cnt == ON_TICKS * OFF_RATIO - 1) begin ns = 2; nc = 0; end else nc = m_cnt + 1;
           end
      endcase
      m_pc = (!run || m_pc == TICK_DIV - 1) ? 0 : m_pc + 1;
      m_fg = !m_s2; m_s3 = m_s2; m_s2 = m_s1; m_s1 = hall1;
      m_st = ns; m_cnt = nc;
    end
  end

  task automatic check(string req, string what, int got, int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    @(negedge clk);
    check(req, "drive_en", int'(drive_en), int'(m_st == 2));
    check(req, "por_active", int'(por_active), int'(m_st == 1));
    check(req, "fg_n", int'(fg_n), int'(m_fg));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "drive_en", int'(drive_en), 0);
    check("R1", "por_active", int'(por_active), 0);
    check("R1", "fg_n", int'(fg_n), 1);
    rst = 1'b0;
    step("R1");
    check("R1", "drive_en after release", int'(drive_en), 0);

    // R3 reset interval length
    run = 1'b1;
    n = 0;
    step("R3");
    while (por_active === 1'b1) begin n++; step("R3"); end
    check("R3", "reset interval cycles", n, POR_CLKS);
    check("R3", "drive_en at interval end", int'(drive_en), 1);

    // R4 on-window timeout with still Hall
    n = 0;
    while (drive_en === 1'b1) begin n++; step("R4"); end
    check("R4", "on-window cycles", n, ON_CLKS);

    // R5 off-window length and automatic re-arm
    n = 0;
    while (drive_en === 1'b0) begin n++; step("R5"); end
    check("R5", "off-window cycles", n, OFF_CLKS);

    // R6 edges faster than the on-window keep drive on
    n = 0;
    for (int i = 0; i < 600; i++) begin
      if (i % 20 == 0) hall1 = ~hall1;
      step("R6");
      if (drive_en !== 1'b1) n++;
    end
    check("R6", "cycles with drive dropped", n, 0);

    // R7 edges during the off-window are ignored
    while (drive_en === 1'b1) step("R7");
    n = 0;
    while (drive_en === 1'b0) begin
      if (n % 10 == 0) hall1 = ~hall1;
      n++;
      step("R7");
    end
    check("R7", "off-window cycles with toggling", n, OFF_CLKS);

    // R2 stop mid-penalty, then fresh restart
    hall1 = 1'b0;
    while (drive_en === 1'b1) step("R2");
    repeat (50) step("R2");
    run = 1'b0;
    step("R2");
    check("R2", "drive_en in stop", int'(drive_en), 0);
    check("R2", "por_active in stop", int'(por_active), 0);
    repeat (7) step("R2");
    run = 1'b1;
    n = 0;
    step("R2");
    while (por_active === 1'b1) begin
      if (n % 3 == 0) hall1 = ~hall1; // R7 edges in the reset interval
      n++;
      step("R2");
    end
    check("R2", "reset interval after restart", n, POR_CLKS);

    // R8 tach latency and polarity
    hall1 = 1'b0;
    repeat (5) step("R8");
    hall1 = 1'b1;
    step("R8"); step("R8");
    check("R8", "fg_n two edges after rise", int'(fg_n), 1);
    step("R8");
    check("R8", "fg_n three edges after rise", int'(fg_n), 0);
    hall1 = 1'b0;
    repeat (3) step("R8");
    check("R8", "fg_n after fall", int'(fg_n), 1);

    // Random phase: Hall periods around the on-window, rare stops
    begin
      int half = 20;
      int left = 20;
      for (int i = 0; i < 40000; i++) begin
        if (left == 0) begin
          hall1 = ~hall1;
          if ($urandom_range(0, 7) == 0) half = $urandom_range(3, 90);
          left = half;
        end else left--;
        if ($urandom_range(0, 2999) == 0) run = ~run;
        if (!run && $urandom_range(0, 19) == 0) run = 1'b1;
        step("R4/R5/R6/R7");
        check("R9", "exclusive outputs", int'(drive_en && por_active), 0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule